// File: doc/BRIEF.md
# Programmable-Rate Asynchronous Serial Transmitter

This block turns bytes from a host into asynchronous serial frames on a single line. The line rests high. Each frame has a low start bit, then 8 data bits sent least-significant bit first, then an optional ninth bit, then a high stop bit. The bit period comes from an 8-bit divisor X and a speed-select pin. With the pin high, a bit lasts 16·(X+1) clock cycles. With it low, a bit lasts 64·(X+1) clock cycles. For example, X = 25 in the fast setting with a 4 MHz clock gives close to 9600 bit/s.

Bytes arrive on a valid/ready stream. A transfer happens on any rising clock edge where `s_valid` and `txbuf_ready` are both high. The host may hold `s_valid` high with stable data for as long as `txbuf_ready` stays low, and no data is lost while it waits. The block holds one waiting byte in a holding stage and one byte in the shifter. The host can therefore hand over the next byte while the current frame is still going out, and the two frames then follow each other with no gap. `txbuf_ready` is also the buffer-empty interrupt flag. A separate pin, `shift_empty`, shows whether the shifter is idle. The master port enable and the transmit enable must both be high for the block to run. Dropping either one clears everything.

Top module: `sertx_top`

## Requirements
- R1: After reset, with both enables low, `tx_line` is 1, `shift_empty` is 1 and `txbuf_ready` is 0.
- R2: While `port_en` or `tx_en` is low, `txbuf_ready` is 0, no byte is taken even if `s_valid` is high, `tx_line` stays 1 and `shift_empty` stays 1.
- R3: When `port_en` and `tx_en` are both high and the holding stage is empty, `txbuf_ready` is 1. It therefore rises in the same cycle that the transmit enable is set.
- R4: With `hi_speed` = 1, every bit of a frame lasts exactly 16·(`divisor`+1) clock cycles.
- R5: With `hi_speed` = 0, every bit of a frame lasts exactly 64·(`divisor`+1) clock cycles.
- R6: With `nine_bit_en` = 0, a frame is 10 bits: start bit 0, data bits 0 to 7 in order, then stop bit 1. The start bit appears on `tx_line` in the second cycle after the accepting edge.
- R7: With `nine_bit_en` = 1, the value of `bit9_val` goes out between data bit 7 and the stop bit. Both `nine_bit_en` and `bit9_val` are captured together with the byte at the accepting edge, so later changes to them do not affect that frame.
- R8: `txbuf_ready` is 0 in the cycle after a transfer. It returns to 1 in the cycle after the byte moves into the shifter. If the shifter is idle, that move happens on the edge right after the transfer.
- R9: `shift_empty` is 0 from the edge that loads a frame until the stop bit has been on the line for its full period. It is 1 at all other times, and whenever it is 1, `tx_line` is 1.
- R10: If a byte is waiting when a stop bit ends, its start bit begins on that same edge. No idle cycle is inserted and `shift_empty` stays 0.
- R11: Clearing `tx_en` in the middle of a frame aborts it and discards any waiting byte. On the next cycle `tx_line` is 1 and `shift_empty` is 1, and after the block is enabled again nothing is sent until a new byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Master serial-port enable |
| tx_en | input | 1 | Transmit enable |
| hi_speed | input | 1 | 1: bit period is 16·(X+1) clocks; 0: bit period is 64·(X+1) clocks |
| divisor | input | 8 | Rate divisor X |
| nine_bit_en | input | 1 | Add a ninth data bit to each frame (captured per byte) |
| bit9_val | input | 1 | Value of the ninth bit (captured per byte) |
| s_valid | input | 1 | Host presents a byte |
| s_data | input | 8 | Byte to send |
| txbuf_ready | output | 1 | Holding stage empty; this is both the stream ready and the interrupt flag |
| shift_empty | output | 1 | Shifter idle |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
A table of frames covers both speed settings at several divisors, in both 8-bit and 9-bit mode, with the ninth bit set to 0 and to 1. Each data byte has its least significant bit set, so the length of the start bit's low run directly measures the bit period. Comparing every clock cycle of the frame against the expected pattern separates a wrong multiplier (16 vs 64), an off-by-one in the divisor, a wrong bit order and a misplaced ninth bit. After each byte is accepted, the bench changes the ninth-bit inputs, which shows whether they were captured at the transfer edge. Directed runs check the following:
- the 9600 bit/s example;
- two queued bytes, where a seamless handover shows up as an immediate second start bit and an idle gap would fail;
- writes attempted with an enable low;
- an abort in the middle of a frame, followed by re-enabling.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              nine;
    logic              b9;
    logic [DATA_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W    = 8,
  parameter int FAST_OVS = 16,
  parameter int SLOW_OVS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hi_speed,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int SUB_W = $clog2(SLOW_OVS);
  localparam int PER_W = DIV_W + SUB_W + 1;

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] sub_last;
  logic             pre_wrap;

  assign sub_last = hi_speed ? SUB_W'(FAST_OVS - 1) : SUB_W'(SLOW_OVS - 1);
  assign pre_wrap = (pre_q == divisor);
  assign tick     = pre_wrap && (sub_q == sub_last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      sub_q <= (sub_q == sub_last) ? '0 : sub_q + SUB_W'(1);
    end else begin
      pre_q <= pre_q + DIV_W'(1);
    end
  end

  // checker: measured tick spacing against (X+1)*oversampling
  logic [PER_W-1:0] chk_cnt;
  logic             chk_ok;
  logic [DIV_W-1:0] div_q;
  logic             hs_q;
  logic [PER_W-1:0] per_exp;

  assign per_exp = ({{(PER_W-DIV_W){1'b0}}, divisor} + PER_W'(1)) *
                   (hi_speed ? PER_W'(FAST_OVS) : PER_W'(SLOW_OVS));

  always_ff @(posedge clk) begin
    div_q <= divisor;
    hs_q  <= hi_speed;
    if (!rst_n) begin
      chk_cnt <= '0;
      chk_ok  <= 1'b0;
    end else begin
      if (restart || tick) chk_cnt <= '0;
      else                 chk_cnt <= chk_cnt + PER_W'(1);
      if (restart)                                 chk_ok <= 1'b1;
      else if (divisor != div_q || hi_speed != hs_q) chk_ok <= 1'b0;
    end
  end

  // R4 and R5: bit period
  p_bit_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok && tick && !restart && divisor == div_q && hi_speed == hs_q)
      |-> (chk_cnt == per_exp - PER_W'(1)));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int FRAME_W = DATA_W + 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     load,
  input  tx_word_t word,
  input  logic     bit_tick,
  output logic     can_load,
  output logic     busy,
  output logic     line
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               last_bit;
  logic [FRAME_W-1:0] frame;

  assign last_bit = busy_q && bit_tick && (cnt_q == '0);
  assign can_load = !busy_q || last_bit;
  assign frame    = {1'b1, (word.nine ? word.b9 : 1'b1), word.data, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= frame;
      cnt_q  <= word.nine ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
      busy_q <= 1'b1;
    end else if (busy_q && bit_tick) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;

  p_load_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> can_load);
  p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> !line);
  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> line);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(FRAME_W));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int FAST_OVS = 16,
  parameter int SLOW_OVS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              hi_speed,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              nine_bit_en,
  input  logic              bit9_val,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              txbuf_ready,
  output logic              shift_empty,
  output logic              tx_line
);
  logic     en;
  logic     buf_full_q;
  tx_word_t buf_q;
  logic     accept;
  logic     load;
  logic     can_load;
  logic     busy;
  logic     bit_tick;

  assign en          = port_en && tx_en;
  assign txbuf_ready = en && !buf_full_q;
  assign accept      = s_valid && txbuf_ready;
  assign load        = en && buf_full_q && can_load;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else if (accept) begin
      buf_full_q <= 1'b1;
      buf_q      <= '{nine: nine_bit_en, b9: bit9_val, data: s_data};
    end else if (load) begin
      buf_full_q <= 1'b0;
    end
  end

  sertx_baud #(
    .DIV_W    (DIV_W),
    .FAST_OVS (FAST_OVS),
    .SLOW_OVS (SLOW_OVS)
  ) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load),
    .hi_speed (hi_speed),
    .divisor  (divisor),
    .tick     (bit_tick)
  );

  sertx_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!en),
    .load     (load),
    .word     (buf_q),
    .bit_tick (bit_tick),
    .can_load (can_load),
    .busy     (busy),
    .line     (tx_line)
  );

  assign shift_empty = !busy;

  p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !txbuf_ready);
  p_load_refills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (txbuf_ready || !(port_en && tx_en)));
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (shift_empty && tx_line));
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> tx_line);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic       clk = 1'b0;
  logic       rst_n, port_en, tx_en, hi_speed, nine_bit_en, bit9_val, s_valid;
  logic [7:0] divisor, s_data;
  logic       txbuf_ready, shift_empty, tx_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
    .hi_speed(hi_speed), .divisor(divisor), .nine_bit_en(nine_bit_en),
    .bit9_val(bit9_val), .s_valid(s_valid), .s_data(s_data),
    .txbuf_ready(txbuf_ready), .shift_empty(shift_empty), .tx_line(tx_line)
  );

  // {hi_speed, divisor, nine, b9, data}; every data byte has bit 0 set
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 8'd0, 1'b0, 1'b0, 8'hA5},
    {1'b1, 8'd2, 1'b0, 1'b0, 8'h3B},
    {1'b0, 8'd0, 1'b0, 1'b0, 8'hFF},
    {1'b0, 8'd1, 1'b1, 1'b1, 8'h01},
    {1'b1, 8'd3, 1'b1, 1'b0, 8'h81},
    {1'b1, 8'd0, 1'b1, 1'b1, 8'h55}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit nine, input bit b9, input logic [7:0] data);
    @(negedge clk);
    while (!txbuf_ready) @(negedge clk);
    nine_bit_en = nine;
    bit9_val    = b9;
    s_data      = data;
    s_valid     = 1'b1;
    @(negedge clk);
    s_valid     = 1'b0;
    nine_bit_en = ~nine;   // R7: later changes must not reach this frame
    bit9_val    = ~b9;
    chk(txbuf_ready == 1'b0, "R8 ready low after transfer", int'(txbuf_ready), 0);
  endtask

  task automatic check_frame(input int per, input bit nine, input bit b9,
                             input logic [7:0] data, input bit immediate,
                             input bit more, input string ptag);
    logic [10:0] fr;
    int nb, bad, firstbad, lowrun, w;
    bit inrun, midbusy;
    fr = {1'b1, (nine ? b9 : 1'b1), data, 1'b0};
    nb = nine ? 11 : 10;
    bad = 0; firstbad = -1; lowrun = 0; inrun = 1'b1; midbusy = 1'b1; w = 0;
    if (!immediate)
      while (tx_line !== 1'b0 && w < 20000) begin
        @(negedge clk);
        w++;
      end
    for (int j = 0; j < nb * per; j++) begin
      if (tx_line !== fr[j / per]) begin
        bad++;
        if (firstbad < 0) firstbad = j;
      end
      if (inrun && tx_line === 1'b0) lowrun++;
      else inrun = 1'b0;
      if (shift_empty !== 1'b0) midbusy = 1'b0;
      @(negedge clk);
    end
    chk(bad == 0, nine ? "R7 nine-bit frame pattern" : "R6 frame pattern", firstbad, -1);
    chk(lowrun == per, ptag, lowrun, per);
    chk(midbusy, "R9 shift_empty low during frame", int'(midbusy), 1);
    if (more)
      chk(tx_line === 1'b0 && shift_empty === 1'b0, "R10 next start bit without gap",
          int'(tx_line), 0);
    else
      chk(tx_line === 1'b1 && shift_empty === 1'b1, "R9 shift_empty after stop",
          int'(shift_empty), 1);
  endtask

  initial begin
    int per, hiw;
    rst_n = 1'b0; port_en = 1'b0; tx_en = 1'b0; hi_speed = 1'b1; divisor = 8'd0;
    nine_bit_en = 1'b0; bit9_val = 1'b0; s_valid = 1'b0; s_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line === 1'b1 && shift_empty === 1'b1 && txbuf_ready === 1'b0,
        "R1 reset state", {tx_line, shift_empty, txbuf_ready}, 3'b110);

    // R2: port disabled, writes refused
    tx_en = 1'b1; s_valid = 1'b1; s_data = 8'h5A;
    hiw = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_line === 1'b1 && shift_empty === 1'b1 && txbuf_ready === 1'b0) hiw++;
    end
    chk(hiw == 20, "R2 no activity while port disabled", hiw, 20);
    s_valid = 1'b0;
    port_en = 1'b1;
    @(negedge clk);
    chk(txbuf_ready === 1'b1, "R3 ready with both enables", int'(txbuf_ready), 1);
    hiw = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_line === 1'b1 && shift_empty === 1'b1) hiw++;
    end
    chk(hiw == 40, "R2 refused write was not queued", hiw, 40);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txbuf_ready === 1'b0, "R2 ready low with tx disabled", int'(txbuf_ready), 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(txbuf_ready === 1'b1, "R3 setting tx enable raises ready", int'(txbuf_ready), 1);

    // table of frames
    for (int v = 0; v < NV; v++) begin
      hi_speed = VEC[v][18];
      divisor  = VEC[v][17:10];
      per = (int'(VEC[v][17:10]) + 1) * (VEC[v][18] ? 16 : 64);
      fork
        send(VEC[v][9], VEC[v][8], VEC[v][7:0]);
        check_frame(per, VEC[v][9], VEC[v][8], VEC[v][7:0], 1'b0, 1'b0,
                    VEC[v][18] ? "R4 fast bit period" : "R5 slow bit period");
      join
      chk(txbuf_ready === 1'b1, "R8 ready restored after move", int'(txbuf_ready), 1);
    end

    // divisor 25, fast setting
    hi_speed = 1'b1; divisor = 8'd25;
    fork
      send(1'b0, 1'b0, 8'h55);
      check_frame(416, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, "R4 divisor 25 period");
    join

    // back-to-back frames
    divisor = 8'd0;
    fork
      begin
        send(1'b0, 1'b0, 8'h0F);
        send(1'b0, 1'b0, 8'hF1);
      end
      begin
        check_frame(16, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b1, "R4 first queued frame");
        check_frame(16, 1'b0, 1'b0, 8'hF1, 1'b1, 1'b0, "R10 second frame period");
      end
    join

    // abort mid-frame
    send(1'b0, 1'b0, 8'h00);
    while (tx_line !== 1'b0) @(negedge clk);
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_line === 1'b1 && shift_empty === 1'b1 && txbuf_ready === 1'b0,
        "R11 abort clears line and shifter", {tx_line, shift_empty, txbuf_ready}, 3'b110);
    tx_en = 1'b1;
    @(negedge clk);
    chk(txbuf_ready === 1'b1, "R3 ready after re-enable", int'(txbuf_ready), 1);
    hiw = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_line === 1'b1 && shift_empty === 1'b1) hiw++;
    end
    chk(hiw == 200, "R11 nothing resent after abort", hiw, 200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule